// File: doc/BRIEF.md
# Panel Power-Up Sequencer

This block powers up a flat panel by walking a fixed order of stages. Each stage raises one enable output, and a programmable wait in milliseconds can follow it. The order is: an initial stage with no output, panel supply, data link enable, backlight supply, backlight PWM run request, and backlight enable. After the last of these the block reaches a terminal done state. A free-running 32-bit microsecond timestamp advances on a tick input. Every wait compares the timestamp against a stored release time, using a signed difference.

A request pulse drives the block. With `block_mode` high, one request runs the whole sequence to completion and waits out every delay by itself. With `block_mode` low, each request moves the sequence forward by at most one stage, and a request made before the current wait has expired is ignored. A presence mask can mark any of the four rails as absent. An absent rail's stage still runs and its wait still applies, but its output stays low.

Top module: `panel_pwrseq`

## Requirements
- R1: After reset all rail outputs, `pwm_run` and `done` are low and `pwm_rate_hz`, `pwm_div`, `pwm_duty` are zero.
- R2: Outputs rise only in the order `panel_vdd`, `lvds_en`, `bl_vdd`, `pwm_run`, `bl_en`, then `done`. No stage is skipped or reordered, and the stage index advances by exactly one when it changes.
- R3: The initial stage acts in the cycle of the request with no wait. After the stage with index N (0 = initial, 1 = panel, 2 = data link, 3 = backlight supply) acts, the next stage waits `dly_N_ms * US_PER_MS` ticks. A zero wait, or the step from the PWM stage to backlight enable, lets the next stage act in the following cycle.
- R4: `present` bit 0 gates `panel_vdd`, bit 1 gates `lvds_en`, bit 2 gates `bl_vdd` and bit 3 gates `bl_en`. When a bit is clear, that output never rises, and the timing of every other output and of `done` is unchanged. `pwm_run` is not maskable.
- R5: While `pwm_run` is high, `pwm_rate_hz` = 32768, `pwm_div` = 1 and `pwm_duty` = 8'hDF. Before it rises all three are zero.
- R6: With `block_mode` low, a request advances at most one stage. A request made before the current wait has expired changes nothing.
- R7: With `block_mode` high, a single request carries the sequence from its current stage to done without further requests.
- R8: Once `done` is high, further requests in either mode leave every output unchanged.
- R9: Time advances only on cycles with `tick_us` high. The release comparison is a signed 32-bit difference, so a wrap of the timestamp does not stall the sequence.
- R10: Asserted outputs stay high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle pulse per microsecond |
| req | input | 1 | Advance request |
| block_mode | input | 1 | 1: run to completion, 0: single step (sampled with `req`) |
| present | input | 4 | Rail presence mask (see R4) |
| dly_0_ms | input | DLY_W | Wait after the initial stage, ms |
| dly_1_ms | input | DLY_W | Wait after panel supply, ms |
| dly_2_ms | input | DLY_W | Wait after data link enable, ms |
| dly_3_ms | input | DLY_W | Wait after backlight supply, ms |
| panel_vdd | output | 1 | Panel supply enable |
| lvds_en | output | 1 | Data link enable |
| bl_vdd | output | 1 | Backlight supply enable |
| pwm_run | output | 1 | Backlight PWM run request |
| pwm_rate_hz | output | 16 | Requested PWM frequency |
| pwm_div | output | 8 | Requested PWM divider |
| pwm_duty | output | 8 | Requested PWM duty code |
| bl_en | output | 1 | Backlight enable |
| done | output | 1 | Sequence complete |

## Verification
The assertions take for granted that the delay inputs are held steady from the request until done. They also assume a blocking request is not mixed with step requests while it is still running. The stimulus sets the delays and mask only while reset is held or the block is idle, and it issues step requests only in runs that have no blocking request outstanding. Delays stay small (0 to 3 ms) and the tick runs every cycle except in the run that holds it low on purpose. Under these conditions the expected rise cycles follow directly from sums of the delays.

// File: rtl/panel_pwrseq.sv
module panel_pwrseq #(
  parameter int TS_W      = 32,
  parameter int DLY_W     = 16,
  parameter int US_PER_MS = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_us,
  input  logic             req,
  input  logic             block_mode,
  input  logic [3:0]       present,
  input  logic [DLY_W-1:0] dly_0_ms,
  input  logic [DLY_W-1:0] dly_1_ms,
  input  logic [DLY_W-1:0] dly_2_ms,
  input  logic [DLY_W-1:0] dly_3_ms,
  output logic             panel_vdd,
  output logic             lvds_en,
  output logic             bl_vdd,
  output logic             pwm_run,
  output logic [15:0]      pwm_rate_hz,
  output logic [7:0]       pwm_div,
  output logic [7:0]       pwm_duty,
  output logic             bl_en,
  output logic             done
);

  typedef enum logic [2:0] {
    S_INIT, S_PANEL, S_LINK, S_BLVDD, S_PWM, S_BLEN, S_DONE
  } stage_e;

  stage_e          stg_q;
  logic [TS_W-1:0] now_q, next_q;
  logic            busy_q;
  logic [DLY_W-1:0] dly_sel;
  logic [TS_W-1:0] wait_us;
  logic            ready, act;

  always_comb begin
    case (stg_q)
      S_INIT:  dly_sel = dly_0_ms;
      S_PANEL: dly_sel = dly_1_ms;
      S_LINK:  dly_sel = dly_2_ms;
      S_BLVDD: dly_sel = dly_3_ms;
      default: dly_sel = '0;
    endcase
  end

  assign wait_us = TS_W'(dly_sel) * TS_W'(US_PER_MS);
  assign ready   = (stg_q == S_INIT) || ($signed(now_q - next_q) >= 0);
  assign act     = (stg_q != S_DONE) && ready && (busy_q || req);
  assign done    = (stg_q == S_DONE);

  assign pwm_rate_hz = pwm_run ? 16'd32768 : 16'd0;
  assign pwm_div     = pwm_run ? 8'd1      : 8'd0;
  assign pwm_duty    = pwm_run ? 8'hDF     : 8'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now_q <= '0;
    end else if (tick_us) begin
      now_q <= now_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q     <= S_INIT;
      next_q    <= '0;
      busy_q    <= 1'b0;
      panel_vdd <= 1'b0;
      lvds_en   <= 1'b0;
      bl_vdd    <= 1'b0;
      pwm_run   <= 1'b0;
      bl_en     <= 1'b0;
    end else begin
      if (req && block_mode && !done) busy_q <= 1'b1;
      if (act) begin
        next_q <= now_q + wait_us;
        stg_q  <= stage_e'(stg_q + 3'd1);
        case (stg_q)
          S_PANEL: panel_vdd <= panel_vdd | present[0];
          S_LINK:  lvds_en   <= lvds_en   | present[1];
          S_BLVDD: bl_vdd    <= bl_vdd    | present[2];
          S_PWM:   pwm_run   <= 1'b1;
          S_BLEN:  begin bl_en <= bl_en | present[3]; busy_q <= 1'b0; end
          default: ;
        endcase
      end
    end
  end

  AST_STAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (stg_q != $past(stg_q)) |-> (stg_q == stage_e'($past(stg_q) + 3'd1))); // R2
  AST_BLEN_AFTER_PWM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bl_en) |-> pwm_run); // R2
  AST_LINK_AFTER_PANEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lvds_en) |-> (panel_vdd || !present[0])); // R4
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    ((stg_q != $past(stg_q)) && !$past(busy_q)) |-> $past(req)); // R6
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && $stable({panel_vdd, lvds_en, bl_vdd, pwm_run, bl_en}))); // R8
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_us |=> $stable(now_q)); // R9
  AST_RAIL_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(panel_vdd) && !$fell(lvds_en) && !$fell(bl_vdd) && !$fell(pwm_run) && !$fell(bl_en)); // R10

endmodule

// File: tb/panel_pwrseq_tb_top.sv
module panel_pwrseq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_us = 1'b1;
  logic req = 1'b0;
  logic block_mode = 1'b0;
  logic [3:0] present = 4'hF;
  logic [15:0] d0 = '0, d1 = '0, d2 = '0, d3 = '0;
  logic panel_vdd, lvds_en, bl_vdd, pwm_run, bl_en, done;
  logic [15:0] pwm_rate_hz;
  logic [7:0] pwm_div, pwm_duty;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  panel_pwrseq dut_i (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .req(req), .block_mode(block_mode),
    .present(present), .dly_0_ms(d0), .dly_1_ms(d1), .dly_2_ms(d2), .dly_3_ms(d3),
    .panel_vdd(panel_vdd), .lvds_en(lvds_en), .bl_vdd(bl_vdd), .pwm_run(pwm_run),
    .pwm_rate_hz(pwm_rate_hz), .pwm_div(pwm_div), .pwm_duty(pwm_duty),
    .bl_en(bl_en), .done(done)
  );

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; req = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse(bit mode);
    @(negedge clk); req = 1'b1; block_mode = mode;
    @(negedge clk); req = 1'b0;
  endtask

  function automatic int gap(int d);
    return (d == 0) ? 1 : d * 1000;
  endfunction

  // Blocking run: measure rise cycles of every output, compare with sums of delays.
  task automatic timed_run(int a, int b, int c, int e, bit [3:0] msk);
    int t_p, t_l, t_v, t_w, t_e, t_d, exp_p, exp_l, exp_v, exp_w;
    d0 = 16'(a); d1 = 16'(b); d2 = 16'(c); d3 = 16'(e); present = msk;
    do_reset();
    t_p = -1; t_l = -1; t_v = -1; t_w = -1; t_e = -1; t_d = -1;
    pulse(1'b1);
    for (int cy = 0; cy < 20000 && t_d < 0; cy++) begin
      if (cy > 0) @(negedge clk);
      if (panel_vdd && t_p < 0) t_p = cy;
      if (lvds_en && t_l < 0) t_l = cy;
      if (bl_vdd && t_v < 0) t_v = cy;
      if (pwm_run && t_w < 0) t_w = cy;
      if (bl_en && t_e < 0) t_e = cy;
      if (done && t_d < 0) t_d = cy;
    end
    exp_p = gap(a); exp_l = exp_p + gap(b); exp_v = exp_l + gap(c); exp_w = exp_v + gap(e);
    chk("R3 panel_vdd rise", t_p, msk[0] ? exp_p : -1);
    chk("R3 lvds_en rise",   t_l, msk[1] ? exp_l : -1);
    chk("R3 bl_vdd rise",    t_v, msk[2] ? exp_v : -1);
    chk("R2 pwm_run rise",   t_w, exp_w);
    chk("R2 bl_en rise",     t_e, msk[3] ? exp_w + 1 : -1);
    chk("R7 done rise",      t_d, exp_w + 1);
    chk("R5 pwm rate", int'(pwm_rate_hz), 32768);
    chk("R5 pwm div",  int'(pwm_div), 1);
    chk("R5 pwm duty", int'(pwm_duty), 8'hDF);
  endtask

  initial begin
    do_reset();
    chk("R1 outputs after reset", int'({panel_vdd, lvds_en, bl_vdd, pwm_run, bl_en, done}), 0);
    chk("R1 pwm fields after reset", int'({pwm_rate_hz, pwm_div, pwm_duty}), 0);

    for (int k = 0; k < 16; k++)
      timed_run(k & 1, (k >> 1) & 1, (k >> 2) & 1, (k >> 3) & 1, 4'hF);
    timed_run(2, 3, 1, 2, 4'hF);
    for (int m = 0; m < 16; m++)
      timed_run(0, 0, 0, 0, 4'(m)); // R4 mask sweep
    timed_run(1, 0, 1, 0, 4'b0101); // R4 with delays

    // Step mode, R6
    d0 = 16'd1; d1 = 16'd1; d2 = 16'd0; d3 = 16'd0; present = 4'hF;
    do_reset();
    pulse(1'b0);
    chk("R6 init step no output", int'(panel_vdd), 0);
    repeat (10) @(negedge clk);
    pulse(1'b0);
    chk("R6 early request ignored", int'(panel_vdd), 0);
    repeat (1000) @(negedge clk);
    pulse(1'b0);
    chk("R6 step raises panel_vdd", int'(panel_vdd), 1);
    chk("R6 step only one stage", int'(lvds_en), 0);
    pulse(1'b0);
    chk("R6 early request after panel ignored", int'(lvds_en), 0);
    repeat (1000) @(negedge clk);
    pulse(1'b0);
    chk("R6 step raises lvds_en", int'(lvds_en), 1);
    chk("R6 bl_vdd still low", int'(bl_vdd), 0);
    pulse(1'b0);
    chk("R3 zero delay step raises bl_vdd", int'(bl_vdd), 1);
    chk("R6 pwm_run still low", int'(pwm_run), 0);
    chk("R5 pwm fields zero before run", int'({pwm_rate_hz, pwm_div, pwm_duty}), 0);
    pulse(1'b1);
    repeat (3) @(negedge clk);
    chk("R7 blocking finish done", int'(done), 1);
    chk("R7 blocking finish outputs", int'({panel_vdd, lvds_en, bl_vdd, pwm_run, bl_en}), 5'h1F);

    // R8: requests after done
    pulse(1'b0);
    pulse(1'b1);
    repeat (5) @(negedge clk);
    chk("R8 outputs hold after done", int'({panel_vdd, lvds_en, bl_vdd, pwm_run, bl_en, done}), 6'h3F);
    chk("R10 pwm_run stays high", int'(pwm_run), 1);

    // R9: no tick, no progress
    d0 = 16'd1; d1 = 16'd0; d2 = 16'd0; d3 = 16'd0; present = 4'hF;
    tick_us = 1'b0;
    do_reset();
    pulse(1'b1);
    repeat (3000) @(negedge clk);
    chk("R9 no tick holds panel_vdd", int'(panel_vdd), 0);
    tick_us = 1'b1;
    repeat (1000) @(negedge clk);
    chk("R9 one tick short", int'(panel_vdd), 0);
    @(negedge clk);
    chk("R9 panel after 1000 ticks", int'(panel_vdd), 1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule